// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is an on-chip sink for a stream of 32-bit trace words. While capture is enabled, every cycle that carries a valid word stores it in a circular RAM at the write pointer and moves the pointer on. When the pointer passes the last location it wraps to zero and raises a sticky full flag, so software knows that older words have been overwritten.

Software reaches the block through a simple word-addressed register port. It can read the RAM size and the status. It can set either pointer while capture is idle. It can drain the RAM through a read-data register that moves the read pointer on after each read. It can preload or clear the RAM through a write-data register that moves the write pointer on after each write.

Capture can end in two ways. With stop-on-trigger armed, a trigger pulse lets a programmed number of further words in, and capture then halts. With stop-on-flush armed, the completion of a manual flush halts capture. A halted block ignores the trace stream until software clears the enable bit and sets it again. A formatter-status register tells software when capture has come to rest.

Top module: `trace_ring_sink`

## Requirements
- R1: A read of the depth register (offset 0x004) returns the RAM size in 32-bit words. Bit 31 is always zero.
- R2: A write to the write-data register (0x024) stores the word at the write pointer and advances the pointer modulo the depth. Such a write is ignored while capture is active.
- R3: A read of the read-data register (0x010) returns the word at the read pointer and advances the pointer modulo the depth. Every read answers on `reg_rdata`, with `reg_rvalid` high, in the cycle after the request.
- R4: A write to the read-pointer register (0x014) or the write-pointer register (0x018) loads that pointer when capture is not active. The same write during active capture is ignored. Both registers read back the current pointer.
- R5: Status (0x00C) bit 0 is the full flag. It is set when the write pointer wraps from depth-1 to 0 by either write path. It is cleared by a load of the write pointer.
- R6: Control (0x020) bit 0 enables capture. While capture is active, each cycle with `trace_valid` high stores `trace_data` at the write pointer and advances it.
- R7: When formatter-control (0x304) bit 13 is set, a trigger pulse during active capture arms a stop. The word in the trigger cycle is stored, then exactly N more valid words are stored, where N is the trigger-count register (0x01C). Capture then halts.
- R8: Writing 1 to formatter-control bit 6 starts a manual flush. `flush_req` and bit 6 read 1 until `flush_done` is seen, and then both return to 0. Formatter-control bits 0, 12 and 13 read back as written.
- R9: When formatter-control bit 12 is set, flush completion during active capture halts capture.
- R10: A halted block stores no trace words, and its write pointer stays still. Capture restarts only after control bit 0 is written to 0 and then to 1.
- R11: Formatter-status (0x300) bit 1 reads 1 whenever capture is not active, either because it is disabled or because it has halted. Bit 1 reads 0 while capture is active. Bit 0 reads 1 while a flush is pending.
- R12: After reset, both pointers, the full flag, the control register, the formatter-control register and the trigger count are zero, and `flush_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_valid | input | 1 | Trace word valid |
| trace_data | input | 32 | Trace word |
| trigger | input | 1 | Trigger event pulse |
| flush_done | input | 1 | Flush-complete pulse |
| flush_req | output | 1 | Manual flush in progress |
| reg_addr | input | 12 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| reg_rvalid | output | 1 | Read data valid |

## Verification
The assertions check on every cycle the properties that do not depend on history:
- read replies arrive exactly one cycle after the request;
- a write-pointer load always leaves the full flag clear;
- a pending flush persists until it is acknowledged;
- a halted or idle block neither stores trace words nor moves its write pointer without a register write.

Only the bench's scenarios can show the following:
- the exact post-trigger word count;
- pointer wrap and the contents returned through the auto-incrementing data register;
- the rejection of pointer writes during capture;
- the disable-then-enable restart sequence.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;
  localparam logic [11:0] A_DEPTH  = 12'h004;
  localparam logic [11:0] A_STAT   = 12'h00C;
  localparam logic [11:0] A_RDATA  = 12'h010;
  localparam logic [11:0] A_RPTR   = 12'h014;
  localparam logic [11:0] A_WPTR   = 12'h018;
  localparam logic [11:0] A_TRGCNT = 12'h01C;
  localparam logic [11:0] A_CTRL   = 12'h020;
  localparam logic [11:0] A_WDATA  = 12'h024;
  localparam logic [11:0] A_FSTAT  = 12'h300;
  localparam logic [11:0] A_FCTRL  = 12'h304;

  localparam int FC_FMT_EN  = 0;
  localparam int FC_FLUSH   = 6;
  localparam int FC_STOP_FL = 12;
  localparam int FC_STOP_TG = 13;

  typedef struct packed {
    logic stop_trg;
    logic stop_flush;
    logic fmt_en;
  } fctl_t;
endpackage

// File: rtl/trc_ram.sv
module trc_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/trc_ptr.sv
module trc_ptr #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr,
  output logic          wrap
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assign wrap = inc && !load && (ptr == LAST);

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/trc_capture_ctl.sv
module trc_capture_ctl
  import trace_ring_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic          ctl_bit,
  input  logic          fc_wr,
  input  logic          fc_en_bit,
  input  logic          fc_flush_bit,
  input  logic          fc_stopfl_bit,
  input  logic          fc_stoptg_bit,
  input  logic [CW-1:0] trig_cnt,
  input  logic          trigger,
  input  logic          trace_valid,
  input  logic          flush_done,
  output logic          cap_en,
  output logic          active,
  output logic          stopped,
  output logic          store,
  output logic          flush_pend,
  output fctl_t         fctl
);
  logic          armed_q;
  logic [CW-1:0] remain_q;
  logic          disable_wr;
  logic          trig_stop;
  logic          flush_stop;

  assign active     = cap_en && !stopped;
  assign disable_wr = ctl_wr && !ctl_bit;
  assign trig_stop  = active && armed_q && (remain_q == '0);
  assign flush_stop = active && flush_pend && flush_done && fctl.stop_flush;
  assign store      = active && trace_valid && !(armed_q && remain_q == '0);

  always_ff @(posedge clk) begin
    if (rst)         cap_en <= 1'b0;
    else if (ctl_wr) cap_en <= ctl_bit;
  end

  always_ff @(posedge clk) begin
    if (rst)                          stopped <= 1'b0;
    else if (disable_wr)              stopped <= 1'b0;
    else if (trig_stop || flush_stop) stopped <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      remain_q <= '0;
    end else if (disable_wr) begin
      armed_q  <= 1'b0;
      remain_q <= '0;
    end else if (active && trigger && fctl.stop_trg && !armed_q) begin
      armed_q  <= 1'b1;
      remain_q <= trig_cnt;
    end else if (store && armed_q) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         flush_pend <= 1'b0;
    else if (fc_wr && fc_flush_bit)  flush_pend <= 1'b1;
    else if (flush_done)             flush_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) fctl <= '0;
    else if (fc_wr) begin
      fctl.fmt_en     <= fc_en_bit;
      fctl.stop_flush <= fc_stopfl_bit;
      fctl.stop_trg   <= fc_stoptg_bit;
    end
  end
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
  import trace_ring_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trace_valid,
  input  logic [DW-1:0] trace_data,
  input  logic          trigger,
  input  logic          flush_done,
  output logic          flush_req,
  input  logic [11:0]   reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          reg_rvalid
);
  logic          cap_en, cap_active, cap_stopped, cap_store, flush_pend;
  fctl_t         fctl;
  logic [31:0]   trig_cnt_q;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_wrap, rd_wrap;
  logic          full_q;
  logic          sw_wptr_ld, sw_rptr_ld, sw_data_we, data_rd;
  logic          ram_we;
  logic [DW-1:0] ram_wdata, ram_q;
  logic          sel_ram_q;
  logic [31:0]   hold_q, rd_mux;

  assign sw_wptr_ld = reg_wr && reg_addr == A_WPTR  && !cap_active;
  assign sw_rptr_ld = reg_wr && reg_addr == A_RPTR  && !cap_active;
  assign sw_data_we = reg_wr && reg_addr == A_WDATA && !cap_active;
  assign data_rd    = reg_rd && reg_addr == A_RDATA;

  trc_capture_ctl #(.CW(32)) u_ctl (
    .clk(clk), .rst(rst),
    .ctl_wr(reg_wr && reg_addr == A_CTRL), .ctl_bit(reg_wdata[0]),
    .fc_wr(reg_wr && reg_addr == A_FCTRL),
    .fc_en_bit(reg_wdata[FC_FMT_EN]), .fc_flush_bit(reg_wdata[FC_FLUSH]),
    .fc_stopfl_bit(reg_wdata[FC_STOP_FL]), .fc_stoptg_bit(reg_wdata[FC_STOP_TG]),
    .trig_cnt(trig_cnt_q), .trigger(trigger), .trace_valid(trace_valid),
    .flush_done(flush_done),
    .cap_en(cap_en), .active(cap_active), .stopped(cap_stopped),
    .store(cap_store), .flush_pend(flush_pend), .fctl(fctl)
  );

  assign flush_req = flush_pend;

  trc_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(clk), .rst(rst), .load(sw_wptr_ld), .load_val(reg_wdata[AW-1:0]),
    .inc(cap_store || sw_data_we), .ptr(wr_ptr), .wrap(wr_wrap)
  );

  trc_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk(clk), .rst(rst), .load(sw_rptr_ld), .load_val(reg_wdata[AW-1:0]),
    .inc(data_rd), .ptr(rd_ptr), .wrap(rd_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst)             full_q <= 1'b0;
    else if (sw_wptr_ld) full_q <= 1'b0;
    else if (wr_wrap)    full_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) trig_cnt_q <= '0;
    else if (reg_wr && reg_addr == A_TRGCNT) trig_cnt_q <= reg_wdata;
  end

  assign ram_we    = cap_store || sw_data_we;
  assign ram_wdata = cap_store ? trace_data : reg_wdata[DW-1:0];

  trc_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .waddr(wr_ptr), .wdata(ram_wdata),
    .re(data_rd), .raddr(rd_ptr), .rdata(ram_q)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_DEPTH:  rd_mux = {1'b0, 31'(DEPTH)};
      A_STAT:   rd_mux = {31'b0, full_q};
      A_RPTR:   rd_mux = 32'(rd_ptr);
      A_WPTR:   rd_mux = 32'(wr_ptr);
      A_TRGCNT: rd_mux = trig_cnt_q;
      A_CTRL:   rd_mux = {31'b0, cap_en};
      A_FSTAT:  rd_mux = {30'b0, !cap_active, flush_pend};
      A_FCTRL: begin
        rd_mux[FC_FMT_EN]  = fctl.fmt_en;
        rd_mux[FC_FLUSH]   = flush_pend;
        rd_mux[FC_STOP_FL] = fctl.stop_flush;
        rd_mux[FC_STOP_TG] = fctl.stop_trg;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      sel_ram_q  <= 1'b0;
      hold_q     <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      sel_ram_q  <= data_rd;
      hold_q     <= rd_mux;
    end
  end

  assign reg_rdata = sel_ram_q ? 32'(ram_q) : hold_q;

  logic unused_ok;
  assign unused_ok = rd_wrap;
endmodule

// File: rtl/trace_ring_sink_chk.sv
module trace_ring_sink_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_rd,
  input logic          reg_rvalid,
  input logic          reg_wr,
  input logic          sw_wptr_ld,
  input logic          full_q,
  input logic          flush_req,
  input logic          flush_done,
  input logic          cap_active,
  input logic          cap_stopped,
  input logic          cap_store,
  input logic [AW-1:0] wr_ptr
);
  p_rvalid_follows_r3: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);
  p_rvalid_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !reg_rvalid);
  p_wptr_load_clears_full_r5: assert property (@(posedge clk) disable iff (rst)
    sw_wptr_ld |=> !full_q);
  p_flush_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (flush_req && !flush_done) |=> flush_req);
  p_halted_no_store_r10: assert property (@(posedge clk) disable iff (rst)
    cap_stopped |-> !cap_store);
  p_idle_wptr_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (!cap_active && !reg_wr) |=> $stable(wr_ptr));
endmodule

bind trace_ring_sink trace_ring_sink_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_rvalid(reg_rvalid),
  .reg_wr(reg_wr), .sw_wptr_ld(sw_wptr_ld), .full_q(full_q),
  .flush_req(flush_req), .flush_done(flush_done), .cap_active(cap_active),
  .cap_stopped(cap_stopped), .cap_store(cap_store), .wr_ptr(wr_ptr)
);

// File: tb/trace_ring_sink_test.sv
module trace_ring_sink_test;
  localparam int DEPTH = 8;
  localparam logic [11:0] DEP = 12'h004, STA = 12'h00C, RDA = 12'h010,
    RPT = 12'h014, WPT = 12'h018, TRC = 12'h01C, CTL = 12'h020,
    WDA = 12'h024, FST = 12'h300, FCT = 12'h304;

  typedef struct packed {
    logic        is_rd;
    logic [11:0] addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VT [NV] = '{
    '{1'b1, DEP, 32'd8,       8'd1},   // R1
    '{1'b1, STA, 32'd0,       8'd12},  // R12
    '{1'b1, CTL, 32'd0,       8'd12},
    '{1'b1, FCT, 32'd0,       8'd12},
    '{1'b1, WPT, 32'd0,       8'd12},
    '{1'b0, WPT, 32'd6,       8'd4},   // R4
    '{1'b0, WDA, 32'h0000_00A0, 8'd2}, // R2
    '{1'b0, WDA, 32'h0000_00A1, 8'd2},
    '{1'b1, WPT, 32'd0,       8'd2},
    '{1'b1, STA, 32'd1,       8'd5},   // R5
    '{1'b0, WDA, 32'h0000_00A2, 8'd2},
    '{1'b0, RPT, 32'd6,       8'd4},
    '{1'b1, RDA, 32'h0000_00A0, 8'd3}, // R3
    '{1'b1, RDA, 32'h0000_00A1, 8'd3},
    '{1'b1, RDA, 32'h0000_00A2, 8'd3},
    '{1'b1, RPT, 32'd1,       8'd3},
    '{1'b0, WPT, 32'd3,       8'd5},
    '{1'b1, STA, 32'd0,       8'd5},
    '{1'b0, TRC, 32'd5,       8'd7},   // R7
    '{1'b1, TRC, 32'd5,       8'd7},
    '{1'b1, FST, 32'd2,       8'd11}   // R11
  };

  logic clk = 1'b0, rst = 1'b1;
  logic trace_valid = 1'b0, trigger = 1'b0, flush_done = 1'b0;
  logic [31:0] trace_data = '0;
  logic flush_req;
  logic [11:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic reg_rvalid;
  int checks = 0, failures = 0;
  logic [31:0] rv;
  bit done = 0;

  always #5 clk = ~clk;

  trace_ring_sink #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .trace_valid(trace_valid), .trace_data(trace_data),
    .trigger(trigger), .flush_done(flush_done), .flush_req(flush_req),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); d = reg_rdata;
    if (reg_rvalid !== 1'b1) begin
      checks++; failures++;
      $display("FAIL R3 rvalid actual=%b expected=1", reg_rvalid);
    end
    reg_rd = 1'b0;
  endtask

  task automatic push(input logic [31:0] d, input logic trg);
    @(negedge clk); trace_valid = 1'b1; trace_data = d; trigger = trg;
    @(negedge clk); trace_valid = 1'b0; trigger = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R12 flush_req", {31'b0, flush_req}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VT[i].is_rd) begin
        rd(VT[i].addr, rv);
        check($sformatf("R%0d vec%0d", VT[i].req, i), rv, VT[i].data);
      end else begin
        wr(VT[i].addr, VT[i].data);
      end
    end

    // R6 capture with a gap in the stream
    wr(WPT, 0);
    wr(CTL, 1);
    rd(FST, rv); check("R11 active", rv, 32'd0);
    push(32'hD0, 0); @(negedge clk); push(32'hD1, 0); push(32'hD2, 0);
    // R4 pointer / R2 data writes ignored during capture
    wr(WPT, 5); wr(WDA, 32'hBAD); wr(RPT, 7);
    rd(WPT, rv); check("R4 wptr ignored", rv, 32'd3);
    rd(RPT, rv); check("R4 rptr ignored", rv, 32'd1);
    wr(CTL, 0);
    wr(RPT, 0);
    rd(RDA, rv); check("R6 word0", rv, 32'hD0);
    rd(RDA, rv); check("R6 word1", rv, 32'hD1);
    rd(RDA, rv); check("R6 word2", rv, 32'hD2);

    // R5 wrap during capture
    wr(WPT, 6); wr(CTL, 1);
    push(32'hE0, 0); push(32'hE1, 0); push(32'hE2, 0);
    wr(CTL, 0);
    rd(STA, rv); check("R5 full by capture", rv, 32'd1);
    rd(WPT, rv); check("R5 wptr wrapped", rv, 32'd1);

    // R7 trigger stop with count 2
    wr(WPT, 0); wr(TRC, 2); wr(FCT, 32'h2001); wr(CTL, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      trace_valid = 1'b1; trace_data = 32'h100 + i; trigger = (i == 3);
    end
    @(negedge clk); trace_valid = 1'b0; trigger = 1'b0;
    rd(WPT, rv); check("R7 post-trigger count", rv, 32'd6);
    rd(FST, rv); check("R11 halted", rv, 32'd2);
    rd(CTL, rv); check("R10 ctl kept", rv, 32'd1);
    rd(FCT, rv); check("R8 fctl readback", rv, 32'h2001);
    wr(RPT, 5);
    rd(RDA, rv); check("R7 last stored word", rv, 32'h105);
    // R10 halted: stream ignored, rewrite of 1 does not restart
    push(32'h200, 0); wr(CTL, 1); push(32'h201, 0);
    rd(WPT, rv); check("R10 halted ignores stream", rv, 32'd6);
    wr(CTL, 0); wr(WPT, 0); wr(CTL, 1);
    push(32'h300, 0); push(32'h301, 0);
    rd(WPT, rv); check("R10 restart after toggle", rv, 32'd2);
    wr(CTL, 0);

    // R8 / R9 flush stop
    wr(WPT, 0); wr(FCT, 32'h1040);
    check("R8 flush_req high", {31'b0, flush_req}, 32'd1);
    rd(FCT, rv); check("R8 flush pending bit", rv, 32'h1040);
    rd(FST, rv); check("R11 flush pending", rv, 32'd3);
    wr(CTL, 1);
    push(32'hF0, 0); push(32'hF1, 0);
    @(negedge clk); flush_done = 1'b1;
    @(negedge clk); flush_done = 1'b0;
    push(32'hF2, 0); push(32'hF3, 0);
    check("R8 flush_req cleared", {31'b0, flush_req}, 32'd0);
    rd(FCT, rv); check("R8 flush bit cleared", rv, 32'h1000);
    rd(WPT, rv); check("R9 flush stop", rv, 32'd2);
    rd(FST, rv); check("R9 halted status", rv, 32'd2);

    // R12 reset mid-operation
    wr(FCT, 32'h0040);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R12 flush_req after reset", {31'b0, flush_req}, 32'd0);
    rd(WPT, rv); check("R12 wptr", rv, 32'd0);
    rd(RPT, rv); check("R12 rptr", rv, 32'd0);
    rd(CTL, rv); check("R12 ctl", rv, 32'd0);
    rd(TRC, rv); check("R12 trig count", rv, 32'd0);
    rd(DEP, rv); check("R1 depth bit31 clear", {rv[31], 31'b0}, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule